// File: doc/BRIEF.md
# Serial Control Bus Output Receiver

This block is the receive side of a discrete output node on a two-wire serial control bus. The bus has one clock line and one data line. A master or clock module drives frames of clock pulses, and each pulse, or pair of pulses, stands for one signal address. A pause in the clock marks the end of a frame. During that pause the data line carries a short low-going fault-check pulse. The node counts pulses from the last pause to find its own address. It samples the data line on the falling clock edge at that address. It keeps the bit pending until the pause that follows shows a well-formed fault-check pulse, and only then passes the bit on to its single discrete output.

The node can be set to run in one of two bus modes. In single-pulse mode there is one pulse per address. In dual-pulse mode there are two pulses per address, and only the second one, which carries output data, is sampled. The node can also run with channel multiplexing, where a channel number is sent at the head of each frame, or with a multi-frame debounce filter. When multiplexing is on, the debounce setting is ignored. If the bus stays silent for too long, or if frames keep failing the fault check, the output drops to its default level, 0. All of the node's logic runs on a local system clock. Both bus lines are synchronised into that clock domain.

Top module: `busrx_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first committed frame, `out_q` is 0.
- R2: The bus clock being low and free of transitions for more than `SYNC_IDLE` system cycles is a frame pause. A pause resets the pulse count. Pulses seen before the first pause after reset or after a clock loss are never sampled.
- R3: In single-pulse mode (`cfg_dual`=0), the bus data level at falling clock edge number `cfg_addr` after the pause is the node's bit. Edges are counted from 0, after any channel header. A high level means 1.
- R4: In dual-pulse mode (`cfg_dual`=1), falling edge number 2*`cfg_addr`+1 is sampled. Edge 2*`cfg_addr`, which is the input half of the slot, is ignored.
- R5: `out_q` changes only in response to the rising clock edge that ends a pause, or to a clock loss. A sampled bit never reaches the output earlier than that.
- R6: A pause's fault-check pulse is valid only if three conditions hold: the data line is high when the pause is detected, the line then goes low exactly once during the pause, and that low lasts `BFD_MIN` to `BFD_MAX` system cycles. If the pulse is not valid, the pending bit is discarded and `out_q` keeps its value.
- R7: `FAIL_LIMIT` consecutive pauses with an invalid fault-check pulse force `out_q` to 0. A valid pulse resets the failure count.
- R8: If the bus clock shows no transition for `LOSS_IDLE` system cycles, `out_q` is forced to 0 and frame alignment is lost.
- R9: With `cfg_mux`=1, the first four falling edges of a frame carry a channel number, least significant bit first. A bit is sampled only in frames whose channel equals `cfg_chan`.
- R10: `cfg_deb` set to 2 or 3 requires that many identical committed values in successive frames before `out_q` changes. The values 0 and 1 apply each committed value at once.
- R11: The debounce run count restarts at 1 when a committed value differs from the previous one. A frame that fails the fault check leaves the count untouched.
- R12: With `cfg_mux`=1, `cfg_deb` has no effect, and every committed value is applied at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_clk | input | 1 | Raw bus clock line level |
| bus_data | input | 1 | Raw bus data line level |
| cfg_addr | input | ADDR_W | Assigned signal address |
| cfg_dual | input | 1 | 1 selects two pulses per address |
| cfg_mux | input | 1 | 1 enables channel multiplexing |
| cfg_chan | input | CH_W | Assigned multiplex channel |
| cfg_deb | input | 2 | Debounce depth (0/1 off, 2, 3) |
| out_q | output | 1 | Discrete external output |

## Verification
The busiest cycle is the one in which a pause ends. In that cycle the fault-check verdict, the debounce run update and the consecutive-failure forcing are all settled together. The bench provokes this cycle in three ways: with a failed pause in the middle of a debounce run, with a run of three bad pauses that hits the failure limit, and with a good pause right after that run. Every frame also checks, just before the pause-ending edge, that the output still shows the previous value. After the edge it checks the new value, so a bit that leaks early or an update that is lost is both caught.

// File: rtl/busrx_pkg.sv
package busrx_pkg;
  typedef enum logic [1:0] {
    BFD_WAIT = 2'd0,
    BFD_LOW  = 2'd1,
    BFD_DONE = 2'd2,
    BFD_BAD  = 2'd3
  } bfd_state_e;
endpackage

// File: rtl/busrx_front.sv
module busrx_front #(
  parameter int SYNC_IDLE = 32,
  parameter int LOSS_IDLE = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk,
  input  logic bus_data,
  output logic data_s,
  output logic fall_s,
  output logic sync_start,
  output logic sync_end,
  output logic in_sync,
  output logic aligned,
  output logic loss_evt
);
  localparam int IDLE_W = $clog2(LOSS_IDLE + 1);

  logic [1:0] clk_pipe, dat_pipe;
  logic clk_d, lost_r;
  logic [IDLE_W-1:0] idle_cnt;
  logic clk_s, edge_any, rise_s;

  assign clk_s    = clk_pipe[1];
  assign data_s   = dat_pipe[1];
  assign edge_any = clk_s ^ clk_d;
  assign rise_s   = clk_s & ~clk_d;
  assign fall_s   = ~clk_s & clk_d;

  assign sync_start = !edge_any && !clk_s && !in_sync && !lost_r &&
                      (idle_cnt == IDLE_W'(SYNC_IDLE));
  assign loss_evt   = !edge_any && !lost_r && (idle_cnt == IDLE_W'(LOSS_IDLE));
  assign sync_end   = rise_s && in_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      clk_d    <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[0], bus_clk};
      dat_pipe <= {dat_pipe[0], bus_data};
      clk_d    <= clk_pipe[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      lost_r   <= 1'b0;
      in_sync  <= 1'b0;
      aligned  <= 1'b0;
    end else begin
      if (edge_any) begin
        idle_cnt <= '0;
        lost_r   <= 1'b0;
      end else begin
        if (idle_cnt != IDLE_W'(LOSS_IDLE)) idle_cnt <= idle_cnt + 1'b1;
        if (loss_evt) lost_r <= 1'b1;
      end
      if (sync_start) begin
        in_sync <= 1'b1;
        aligned <= 1'b1;
      end else if (loss_evt) begin
        in_sync <= 1'b0;
        aligned <= 1'b0;
      end else if (rise_s) begin
        in_sync <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/busrx_slot.sv
module busrx_slot #(
  parameter int ADDR_W = 8,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_s,
  input  logic              data_s,
  input  logic              sync_end,
  input  logic              loss_evt,
  input  logic              count_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_dual,
  input  logic              cfg_mux,
  input  logic [CH_W-1:0]   cfg_chan,
  output logic              held_v,
  output logic              held_d
);
  localparam int PIDX_W = ADDR_W + 2;
  localparam logic [PIDX_W-1:0] PIDX_MAX = '1;

  logic [PIDX_W-1:0] pidx, hdr_len, slot, target;
  logic [CH_W-1:0]   chan_rx;
  logic in_hdr, chan_ok, hit;

  assign hdr_len = cfg_mux ? PIDX_W'(CH_W) : '0;
  assign slot    = pidx - hdr_len;
  assign target  = cfg_dual ? {1'b0, cfg_addr, 1'b1} : {2'b00, cfg_addr};
  assign in_hdr  = cfg_mux && (pidx < hdr_len);
  assign chan_ok = !cfg_mux || (chan_rx == cfg_chan);
  assign hit     = count_en && fall_s && !in_hdr && chan_ok &&
                   (slot == target) && (pidx != PIDX_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pidx    <= '0;
      chan_rx <= '0;
      held_v  <= 1'b0;
      held_d  <= 1'b0;
    end else if (loss_evt || sync_end) begin
      pidx   <= '0;
      held_v <= 1'b0;
    end else if (count_en && fall_s) begin
      if (pidx != PIDX_MAX) pidx <= pidx + 1'b1;
      for (int i = 0; i < CH_W; i++) begin
        if (in_hdr && (pidx == PIDX_W'(i))) chan_rx[i] <= data_s;
      end
      if (hit) begin
        held_v <= 1'b1;
        held_d <= data_s;
      end
    end
  end
endmodule

// File: rtl/busrx_bfd.sv
module busrx_bfd
  import busrx_pkg::*;
#(
  parameter int BFD_MIN = 2,
  parameter int BFD_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_start,
  input  logic in_sync,
  input  logic data_s,
  output logic bfd_ok
);
  localparam int LEN_W = $clog2(BFD_MAX + 2);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(BFD_MAX + 1);

  bfd_state_e st;
  logic [LEN_W-1:0] len;
  logic len_fits;

  assign len_fits = (len >= LEN_W'(BFD_MIN)) && (len <= LEN_W'(BFD_MAX));
  assign bfd_ok   = (st == BFD_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= BFD_BAD;
      len <= '0;
    end else if (sync_start) begin
      st  <= data_s ? BFD_WAIT : BFD_BAD;
      len <= '0;
    end else if (in_sync) begin
      case (st)
        BFD_WAIT: if (!data_s) begin
          st  <= BFD_LOW;
          len <= LEN_W'(1);
        end
        BFD_LOW: begin
          if (!data_s) begin
            if (len != LEN_SAT) len <= len + 1'b1;
          end else begin
            st <= len_fits ? BFD_DONE : BFD_BAD;
          end
        end
        BFD_DONE: if (!data_s) st <= BFD_BAD;
        default: st <= BFD_BAD;
      endcase
    end
  end
endmodule

// File: rtl/busrx_debounce.sv
module busrx_debounce (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic       sample,
  input  logic [1:0] depth,
  input  logic       force_dflt,
  output logic       out_q
);
  logic       last_v;
  logic [1:0] run_cnt, run_nxt;

  always_comb begin
    if ((sample == last_v) && (run_cnt != 2'd0))
      run_nxt = (run_cnt == 2'd3) ? 2'd3 : run_cnt + 2'd1;
    else
      run_nxt = 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || force_dflt) begin
      out_q   <= 1'b0;
      last_v  <= 1'b0;
      run_cnt <= 2'd0;
    end else if (commit) begin
      last_v  <= sample;
      run_cnt <= run_nxt;
      if (run_nxt >= depth) out_q <= sample;
    end
  end
endmodule

// File: rtl/busrx_top.sv
module busrx_top #(
  parameter int ADDR_W     = 8,
  parameter int CH_W       = 4,
  parameter int SYNC_IDLE  = 32,
  parameter int LOSS_IDLE  = 400,
  parameter int BFD_MIN    = 2,
  parameter int BFD_MAX    = 16,
  parameter int FAIL_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              bus_data,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_dual,
  input  logic              cfg_mux,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [1:0]        cfg_deb,
  output logic              out_q
);
  localparam int FW = $clog2(FAIL_LIMIT + 1);

  logic data_s, fall_s, sync_start, sync_end, in_sync, aligned, loss_evt;
  logic held_v, held_d, bfd_ok, commit, fail_force, force_dflt;
  logic [1:0] depth_eff;
  logic [FW-1:0] fails;

  busrx_front #(.SYNC_IDLE(SYNC_IDLE), .LOSS_IDLE(LOSS_IDLE)) u_front (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
    .data_s(data_s), .fall_s(fall_s), .sync_start(sync_start),
    .sync_end(sync_end), .in_sync(in_sync), .aligned(aligned),
    .loss_evt(loss_evt)
  );

  busrx_slot #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .fall_s(fall_s), .data_s(data_s),
    .sync_end(sync_end), .loss_evt(loss_evt), .count_en(aligned && !in_sync),
    .cfg_addr(cfg_addr), .cfg_dual(cfg_dual), .cfg_mux(cfg_mux),
    .cfg_chan(cfg_chan), .held_v(held_v), .held_d(held_d)
  );

  busrx_bfd #(.BFD_MIN(BFD_MIN), .BFD_MAX(BFD_MAX)) u_bfd (
    .clk(clk), .rst_n(rst_n), .sync_start(sync_start), .in_sync(in_sync),
    .data_s(data_s), .bfd_ok(bfd_ok)
  );

  assign depth_eff  = (cfg_mux || (cfg_deb < 2'd2)) ? 2'd1 : cfg_deb;
  assign commit     = sync_end && bfd_ok && held_v;
  assign fail_force = sync_end && !bfd_ok && (fails >= FW'(FAIL_LIMIT - 1));
  assign force_dflt = loss_evt || fail_force;

  always_ff @(posedge clk) begin
    if (!rst_n || loss_evt) begin
      fails <= '0;
    end else if (sync_end) begin
      if (bfd_ok) fails <= '0;
      else if (fails != FW'(FAIL_LIMIT)) fails <= fails + 1'b1;
    end
  end

  busrx_debounce u_deb (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sample(held_d),
    .depth(depth_eff), .force_dflt(force_dflt), .out_q(out_q)
  );
endmodule

// File: rtl/busrx_chk.sv
module busrx_chk (
  input logic clk,
  input logic rst_n,
  input logic out_q,
  input logic sync_end,
  input logic loss_evt,
  input logic bfd_ok,
  input logic fail_force,
  input logic held_v,
  input logic held_d,
  input logic fall_s,
  input logic commit,
  input logic cfg_mux
);
  p_out_moves_at_frame_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> ($past(sync_end) || $past(loss_evt)));

  p_loss_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loss_evt |=> !out_q);

  p_bad_pulse_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_end && !bfd_ok && !fail_force) |=> $stable(out_q));

  p_fail_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_force |=> !out_q);

  p_mux_no_debounce_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cfg_mux) |=> (out_q == $past(held_d)));

  p_capture_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_v) |-> $past(fall_s));
endmodule

bind busrx_top busrx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_q(out_q), .sync_end(sync_end),
  .loss_evt(loss_evt), .bfd_ok(bfd_ok), .fail_force(fail_force),
  .held_v(held_v), .held_d(held_d), .fall_s(fall_s), .commit(commit),
  .cfg_mux(cfg_mux)
);

// File: tb/sim_busrx_top.sv
module sim_busrx_top;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_clk, bus_data;
  logic [7:0] cfg_addr;
  logic cfg_dual, cfg_mux;
  logic [3:0] cfg_chan;
  logic [1:0] cfg_deb;
  logic out_q;

  always #2 clk = ~clk;

  busrx_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
    .cfg_addr(cfg_addr), .cfg_dual(cfg_dual), .cfg_mux(cfg_mux),
    .cfg_chan(cfg_chan), .cfg_deb(cfg_deb), .out_q(out_q)
  );

  localparam int HALF = 8;
  localparam int SYNC_WAIT = 40;
  localparam int NV = 27;
  // {tag[4], dual, mux, chan[4], deb[2], sent_chan[4], v, bfd[2], exp}
  // bfd: 0 good pulse, 1 none, 2 too long
  localparam logic [19:0] VEC [NV] = '{
    {4'd3, 1'b0,1'b0,4'd0,2'd0,4'd0,1'b1,2'd0,1'b1},
    {4'd3, 1'b0,1'b0,4'd0,2'd0,4'd0,1'b0,2'd0,1'b0},
    {4'd5, 1'b0,1'b0,4'd0,2'd0,4'd0,1'b1,2'd0,1'b1},
    {4'd4, 1'b1,1'b0,4'd0,2'd0,4'd0,1'b0,2'd0,1'b0},
    {4'd4, 1'b1,1'b0,4'd0,2'd0,4'd0,1'b1,2'd0,1'b1},
    {4'd6, 1'b0,1'b0,4'd0,2'd0,4'd0,1'b0,2'd1,1'b1},
    {4'd6, 1'b0,1'b0,4'd0,2'd0,4'd0,1'b0,2'd2,1'b1},
    {4'd6, 1'b0,1'b0,4'd0,2'd0,4'd0,1'b0,2'd0,1'b0},
    {4'd10,1'b0,1'b0,4'd0,2'd2,4'd0,1'b1,2'd0,1'b0},
    {4'd10,1'b0,1'b0,4'd0,2'd2,4'd0,1'b1,2'd0,1'b1},
    {4'd11,1'b0,1'b0,4'd0,2'd2,4'd0,1'b0,2'd1,1'b1},
    {4'd11,1'b0,1'b0,4'd0,2'd2,4'd0,1'b0,2'd0,1'b1},
    {4'd11,1'b0,1'b0,4'd0,2'd2,4'd0,1'b1,2'd0,1'b1},
    {4'd11,1'b0,1'b0,4'd0,2'd2,4'd0,1'b0,2'd0,1'b1},
    {4'd10,1'b0,1'b0,4'd0,2'd2,4'd0,1'b0,2'd0,1'b0},
    {4'd10,1'b0,1'b0,4'd0,2'd3,4'd0,1'b1,2'd0,1'b0},
    {4'd10,1'b0,1'b0,4'd0,2'd3,4'd0,1'b1,2'd0,1'b0},
    {4'd10,1'b0,1'b0,4'd0,2'd3,4'd0,1'b1,2'd0,1'b1},
    {4'd10,1'b0,1'b0,4'd0,2'd3,4'd0,1'b0,2'd0,1'b1},
    {4'd10,1'b0,1'b0,4'd0,2'd3,4'd0,1'b0,2'd0,1'b1},
    {4'd10,1'b0,1'b0,4'd0,2'd3,4'd0,1'b0,2'd0,1'b0},
    {4'd9, 1'b0,1'b1,4'd9,2'd0,4'd9,1'b1,2'd0,1'b1},
    {4'd9, 1'b0,1'b1,4'd9,2'd0,4'd3,1'b0,2'd0,1'b1},
    {4'd9, 1'b0,1'b1,4'd9,2'd0,4'd9,1'b0,2'd0,1'b0},
    {4'd12,1'b0,1'b1,4'd9,2'd3,4'd9,1'b1,2'd0,1'b1},
    {4'd12,1'b0,1'b1,4'd9,2'd3,4'd9,1'b0,2'd0,1'b0},
    {4'd9, 1'b1,1'b1,4'd9,2'd0,4'd9,1'b1,2'd0,1'b1}
  };

  int n_chk = 0;
  int n_fail = 0;
  logic prev_exp;

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input logic exp, input string req, input string what);
    n_chk++;
    if (out_q !== exp) begin
      n_fail++;
      $display("FAIL %s %s: out_q=%0b expected %0b", req, what, out_q, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one frame: pulses, pause with fault-check pulse, pause-ending rise
  task automatic frame(input int n_addr, input logic v, input int ch_sent, input int bfd);
    int hdr = cfg_mux ? 4 : 0;
    int np = hdr + (cfg_dual ? 2 : 1) * n_addr;
    for (int i = 0; i < np; i++) begin
      logic b;
      int q = i - hdr;
      if (i < hdr) b = ((ch_sent >> i) & 1) != 0;
      else if (cfg_dual) b = ((q / 2) == int'(cfg_addr) && (q % 2) == 1) ? v : ~v;
      else b = (q == int'(cfg_addr)) ? v : ~v;
      bus_data = b;
      waitn(HALF);
      bus_clk = 1'b0;
      waitn(HALF);
      if (i < np - 1) bus_clk = 1'b1;
    end
    bus_data = 1'b1;
    waitn(SYNC_WAIT);
    if (bfd == 0) begin
      bus_data = 1'b0; waitn(6); bus_data = 1'b1;
    end else if (bfd == 2) begin
      bus_data = 1'b0; waitn(30); bus_data = 1'b1;
    end
    waitn(10);
    check(prev_exp, "R5", "output held until pause ends");
    bus_clk = 1'b1;
    waitn(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_clk = 1'b0; bus_data = 1'b1;
    cfg_addr = 8'd5; cfg_dual = 1'b0; cfg_mux = 1'b0; cfg_chan = 4'd0; cfg_deb = 2'd0;
    waitn(5);
    check(1'b0, "R1", "during reset");
    rst_n = 1'b1;
    waitn(3);
    check(1'b0, "R1", "after reset");
    bus_clk = 1'b1;
    waitn(HALF);
    prev_exp = 1'b0;
    frame(16, 1'b1, 0, 0);
    check(1'b0, "R2", "frame before first pause ignored");

    for (int k = 0; k < NV; k++) begin
      logic [19:0] vv = VEC[k];
      cfg_dual = vv[15]; cfg_mux = vv[14]; cfg_chan = vv[13:10]; cfg_deb = vv[9:8];
      frame(16, vv[3], int'(vv[7:4]), int'(vv[2:1]));
      check(vv[0], tag_name(int'(vv[19:16])), $sformatf("vector %0d", k));
      prev_exp = vv[0];
    end

    // consecutive bad pauses (dual, mux on, channel 9)
    frame(16, 1'b0, 9, 1); check(1'b1, "R7", "first bad pause");
    frame(16, 1'b0, 9, 2); check(1'b1, "R7", "second bad pause");
    frame(16, 1'b0, 9, 1); check(1'b0, "R7", "limit reached"); prev_exp = 1'b0;
    frame(16, 1'b1, 9, 0); check(1'b1, "R7", "recovery after good pause"); prev_exp = 1'b1;

    // clock loss
    waitn(200); check(1'b1, "R8", "idle below loss limit");
    waitn(300); check(1'b0, "R8", "idle beyond loss limit");
    prev_exp = 1'b0;
    frame(16, 1'b1, 9, 0); check(1'b0, "R8", "first frame after loss not aligned");
    frame(16, 1'b1, 9, 0); check(1'b1, "R8", "realigned frame"); prev_exp = 1'b1;

    // address boundaries
    cfg_mux = 1'b0; cfg_dual = 1'b0; cfg_deb = 2'd0; cfg_addr = 8'd255;
    frame(256, 1'b0, 0, 0); check(1'b0, "R3", "top address"); prev_exp = 1'b0;
    cfg_dual = 1'b1;
    frame(256, 1'b1, 0, 0); check(1'b1, "R4", "top address dual"); prev_exp = 1'b1;
    cfg_dual = 1'b0; cfg_addr = 8'd0;
    frame(16, 1'b0, 0, 0); check(1'b0, "R3", "address zero"); prev_exp = 1'b0;

    finish_run();
  end
endmodule